// File: doc/BRIEF.md
# Outbound write posting queue

This block posts write transactions from an internal bus master toward an external PCI-X style bus. Each accepted write leaves its address, command type (memory or I/O) and beat count in a small address queue. Its payload beats go into a separate circular data buffer. Once a transaction's payload has fully arrived, the oldest queued write is presented to a downstream bus-master engine. That engine pulls the payload one beat at a time and then reports a termination status.

Address entries and payload are retired separately. A clean completion releases the address entry, and its payload has already been consumed by the beat pulls. A master abort or a target abort also releases the address entry, and it discards whatever payload beats of that transaction were not yet pulled, which frees the buffer space at once. The requester is held off whenever the address queue is full, the buffer lacks room for the offered length, or a payload is still being loaded.

Top module: `wr_post_queue`

## Requirements
- R1: After reset, `dn_valid` and `wd_ready` are 0, and `req_ready` is 1 for any legal length.
- R2: At most `AQ_DEPTH` (default 4) writes are held. With that many queued, `req_ready` is 0.
- R3: A request is accepted only if its length is between 1 and `MAX_BEATS` and the free buffer words (`BUF_BYTES*8/DATA_W`) are at least that length. A request failing this is stalled even when an address slot is free.
- R4: Writes are presented downstream in acceptance order. `dn_addr`, `dn_io` (1 = I/O write, 0 = memory write) and `dn_len` show the head entry and hold steady until that entry retires.
- R5: `dn_valid` rises only on the cycle after the last payload beat of the head write has been accepted.
- R6: Each `dn_beat` while `dn_valid` pulls one beat. `dn_data` shows the head write's beats in the order they were written.
- R7: `dn_done` with `dn_status` = 2'b00 (normal completion) retires the head entry only after all of its beats have been pulled. Before that point it is ignored.
- R8: `dn_done` with a nonzero `dn_status` (2'b01 master abort, 2'b10 target abort) retires the head entry at once and discards its unpulled beats. The next write's data is correct and the discarded words are free again.
- R9: While a payload is loading, `wd_ready` is 1 and `req_ready` is 0. Otherwise `wd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Target bus address |
| req_io | input | 1 | 1 = I/O write, 0 = memory write |
| req_len | input | LEN_W | Payload length in beats |
| wd_valid | input | 1 | Payload beat offered |
| wd_ready | output | 1 | Payload beat taken when high with wd_valid |
| wd_data | input | DATA_W | Payload beat |
| dn_valid | output | 1 | Head write ready for the bus engine |
| dn_addr | output | ADDR_W | Head write address |
| dn_io | output | 1 | Head write command type |
| dn_len | output | LEN_W | Head write length in beats |
| dn_data | output | DATA_W | Next beat of the head write |
| dn_beat | input | 1 | Pull one beat of the head write |
| dn_done | input | 1 | Head write terminated |
| dn_status | input | 2 | 00 completion, 01 master abort, 10 target abort |

## Verification
A stale read pointer after an abort shows up as wrong `dn_data` on the very first beat of the following write. A miscounted buffer occupancy shows up as `req_ready` disagreeing with the free-space model on the next offered request. A head pointer that moves on an early completion shows as `dn_addr` changing one cycle after the ignored `dn_done`. A wrongly released fill state shows as `dn_valid` rising before the last payload beat, or `req_ready` rising during a load.

// File: rtl/wr_post_queue.sv
module wr_post_queue #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int AQ_DEPTH  = 4,
  parameter int BUF_BYTES = 4096,
  parameter int MAX_BEATS = 64,
  localparam int LEN_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              dn_valid,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_io,
  output logic [LEN_W-1:0]  dn_len,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_beat,
  input  logic              dn_done,
  input  logic [1:0]        dn_status
);
  localparam int WORDS = BUF_BYTES * 8 / DATA_W;
  localparam int PW    = $clog2(WORDS);
  localparam int QW    = $clog2(AQ_DEPTH);

  logic [DATA_W-1:0] mem     [WORDS];
  logic [ADDR_W-1:0] q_addr  [AQ_DEPTH];
  logic              q_io    [AQ_DEPTH];
  logic [LEN_W-1:0]  q_len   [AQ_DEPTH];

  logic [QW:0]       q_wp, q_rp;
  logic [PW:0]       b_wp, b_rp;
  logic [LEN_W-1:0]  fill_left, taken;
  logic              filling;

  wire [QW:0]   q_cnt  = q_wp - q_rp;
  wire [PW:0]   used   = b_wp - b_rp;
  wire          q_full = (q_cnt == (QW+1)'(AQ_DEPTH));
  wire [QW-1:0] hd     = q_rp[QW-1:0];
  wire [QW-1:0] tl     = q_wp[QW-1:0];

  wire len_ok = (req_len != '0) && (32'(req_len) <= 32'(MAX_BEATS)) &&
                (32'(req_len) + 32'(used) <= 32'(WORDS));

  assign req_ready = !q_full && !filling && len_ok;
  assign wd_ready  = filling;
  assign dn_valid  = (q_cnt != '0) && !(filling && q_cnt == (QW+1)'(1));
  assign dn_addr   = q_addr[hd];
  assign dn_io     = q_io[hd];
  assign dn_len    = q_len[hd];
  assign dn_data   = mem[b_rp[PW-1:0]];

  wire req_fire  = req_valid && req_ready;
  wire wd_fire   = wd_valid && filling;
  wire is_abort  = (dn_status != 2'b00);
  wire beat_fire = dn_valid && dn_beat && !dn_done && (taken != dn_len);
  wire done_fire = dn_valid && dn_done && (is_abort || taken == dn_len);

  always_ff @(posedge clk) begin
    if (req_fire) begin
      q_addr[tl] <= req_addr;
      q_io[tl]   <= req_io;
      q_len[tl]  <= req_len;
    end
    if (wd_fire) mem[b_wp[PW-1:0]] <= wd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_wp      <= '0;
      q_rp      <= '0;
      b_wp      <= '0;
      b_rp      <= '0;
      fill_left <= '0;
      taken     <= '0;
      filling   <= 1'b0;
    end else begin
      if (req_fire) begin
        q_wp      <= q_wp + 1'b1;
        filling   <= 1'b1;
        fill_left <= req_len;
      end
      if (wd_fire) begin
        b_wp      <= b_wp + 1'b1;
        fill_left <= fill_left - 1'b1;
        if (fill_left == LEN_W'(1)) filling <= 1'b0;
      end
      if (beat_fire) begin
        b_rp  <= b_rp + 1'b1;
        taken <= taken + 1'b1;
      end
      if (done_fire) begin
        q_rp  <= q_rp + 1'b1;
        taken <= '0;
        if (is_abort) b_rp <= b_rp + (PW+1)'(dn_len - taken);
      end
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (QW+1)'(AQ_DEPTH));

  p_buf_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used) <= 32'(WORDS));

  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_done) |=> (dn_valid && $stable(dn_addr) && $stable(dn_len) && $stable(dn_io)));

  p_early_ok_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_done && dn_status == 2'b00 && taken != dn_len) |=> (dn_valid && $stable(q_rp)));

  p_abort_pops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_done && dn_status != 2'b00) |=> (q_rp != $past(q_rp)));

  p_fill_has_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (q_cnt != '0 && !req_ready));
endmodule

// File: tb/test_wr_post_queue.sv
module test_wr_post_queue;
  localparam int AW = 32, DW = 32, QD = 4, BB = 64, MB = 16;
  localparam int LW = $clog2(MB + 1);
  localparam int WORDS = BB * 8 / DW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_io = 0, wd_valid = 0, dn_beat = 0, dn_done = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [DW-1:0] wd_data = '0;
  logic [1:0] dn_status = '0;
  logic req_ready, wd_ready, dn_valid, dn_io;
  logic [AW-1:0] dn_addr;
  logic [LW-1:0] dn_len;
  logic [DW-1:0] dn_data;

  always #5 clk = ~clk;

  wr_post_queue #(.ADDR_W(AW), .DATA_W(DW), .AQ_DEPTH(QD), .BUF_BYTES(BB), .MAX_BEATS(MB)) i_wr_post_queue (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_io(req_io), .req_len(req_len), .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_io(dn_io), .dn_len(dn_len), .dn_data(dn_data),
    .dn_beat(dn_beat), .dn_done(dn_done), .dn_status(dn_status));

  int checks = 0, fails = 0;
  logic [AW-1:0] m_addr [QD];
  logic          m_io   [QD];
  int            m_len  [QD];
  logic [DW-1:0] m_data [QD][MB];
  int mh = 0, mc = 0, m_taken = 0, m_used = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int len);
    return mc < QD && len >= 1 && len <= MB && m_used + len <= WORDS;
  endfunction

  task automatic probe(input int len, input bit exp);
    @(negedge clk);
    req_valid = 1; req_len = LW'(len); #1;
    chk(req_ready == exp, "R3/R2 req_ready", 64'(req_ready), 64'(exp));
    req_valid = 0;
  endtask

  task automatic send(input logic [AW-1:0] a, input bit io, input int len);
    int slot = (mh + mc) % QD;
    bit was_empty = (mc == 0);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_io = io; req_len = LW'(len); #1;
    chk(req_ready == exp_ready(len), "R3 accept", 64'(req_ready), 64'(exp_ready(len)));
    if (!req_ready) begin req_valid = 0; return; end
    m_addr[slot] = a; m_io[slot] = io; m_len[slot] = len;
    @(negedge clk);
    req_valid = 0; #1;
    chk(wd_ready == 1 && req_ready == 0, "R9 load gate", {wd_ready, req_ready}, 2'b10);
    for (int i = 0; i < len; i++) begin
      m_data[slot][i] = $urandom;
      wd_valid = 1; wd_data = m_data[slot][i]; #1;
      if (was_empty) chk(dn_valid == 0, "R5 early valid", 64'(dn_valid), 0);
      @(negedge clk);
    end
    wd_valid = 0; #1;
    mc++; m_used += len;
    chk(wd_ready == 0, "R9 wd_ready idle", 64'(wd_ready), 0);
    if (was_empty) chk(dn_valid == 1, "R5 valid after load", 64'(dn_valid), 1);
  endtask

  task automatic drain(input int take, input logic [1:0] st);
    @(negedge clk); #1;
    chk(dn_valid == 1, "R4 head valid", 64'(dn_valid), 1);
    chk(dn_addr == m_addr[mh] && dn_io == m_io[mh], "R4 head addr/io", {dn_io, dn_addr}, {m_io[mh], m_addr[mh]});
    chk(int'(dn_len) == m_len[mh], "R4 head len", 64'(dn_len), 64'(m_len[mh]));
    for (int i = 0; i < take; i++) begin
      dn_beat = 1; #1;
      chk(dn_data == m_data[mh][m_taken], "R6 beat data", dn_data, m_data[mh][m_taken]);
      @(negedge clk);
      m_taken++; m_used--;
    end
    dn_beat = 0; dn_done = 1; dn_status = st;
    @(negedge clk);
    dn_done = 0; dn_status = 0; #1;
    if (st == 2'b00 && m_taken != m_len[mh]) begin
      chk(dn_valid == 1 && dn_addr == m_addr[mh], "R7 early completion ignored", dn_addr, m_addr[mh]);
    end else begin
      if (st != 2'b00) m_used -= m_len[mh] - m_taken;
      mh = (mh + 1) % QD; mc--; m_taken = 0;
      if (mc > 0) chk(dn_addr == m_addr[mh], "R8/R7 next head", dn_addr, m_addr[mh]);
    end
  endtask

  task automatic finish_rest(input int st);
    drain(m_len[mh] - m_taken, 2'(st));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R5 watchdog act=hang exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7041));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    req_len = 1; #1;
    chk(dn_valid == 0 && wd_ready == 0, "R1 reset outputs", {dn_valid, wd_ready}, 0);
    chk(req_ready == 1, "R1 reset ready", 64'(req_ready), 1);

    // R2: four entries fill the address queue
    send(32'h1000, 0, 2); send(32'h2000, 1, 2); send(32'h3000, 0, 2); send(32'h4000, 1, 2);
    probe(1, 0);
    drain(0, 2'b00);            // R7 early completion ignored
    finish_rest(0);
    probe(1, 1);
    finish_rest(0); finish_rest(0); finish_rest(0);

    // R3: buffer space stall with address slots free
    send(32'h5000, 0, 10);
    probe(7, 0); probe(6, 1); probe(0, 0); probe(MB + 1, 0);
    // R8: master abort after partial pull reclaims space
    send(32'h6000, 1, 3);
    drain(4, 2'b01);
    probe(13, 1);
    drain(1, 2'b10);            // R8 target abort, next head data checked
    send(32'h7000, 0, 16);
    finish_rest(0);

    for (int it = 0; it < 300; it++) begin
      if (($urandom % 2 == 0 || mc == 0) && mc < QD) begin
        int len = 1 + $urandom % MB;
        if (m_used + len <= WORDS) send($urandom, 1'($urandom), len);
        else probe(len, 0);
      end else if (mc > 0) begin
        int st = $urandom % 4;
        int rem = m_len[mh] - m_taken;
        if (st == 3) st = 0;
        drain(st == 0 && ($urandom % 4 != 0) ? rem : $urandom % (rem + 1), 2'(st));
      end else begin
        probe(1, 0);
      end
    end
    while (mc > 0) finish_rest(0);
    probe(MB, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule